// File: doc/BRIEF.md
# Serial Configuration Bitstream Memory

This block is a clocked model of a one-bit-wide memory that feeds a stored configuration bitstream, one bit per clock, into an FPGA loader. The loader supplies the clock and two controls. An active-low chip enable gates all activity and puts the part in standby. A single dual-purpose line clears the internal read pointer and, at the same time, disables the data output. The active level of that line is chosen by a parameter.

On every edge where the part is enabled and not held clear, the bit at the current pointer goes to the data output and the pointer steps forward. The pointer stops at the last address. It also keeps its value while the chip enable is off, as long as the clear line stays inactive. A loader can therefore read several images stored one after another by toggling the chip enable between them.

A preload write port lets a testbench fill the array before streaming starts. All controls are sampled on the rising clock edge. Inside the block, a four-state machine records the outcome of the last edge:
- SLEEP: chip enable off.
- CLEAR: pointer held at zero.
- RUN: a bit was emitted and the pointer was below the last address.
- END: the last address has been emitted.

From any state, the next state is chosen in this order. An edge with chip enable off goes to SLEEP. Otherwise an edge with the clear line active goes to CLEAR. Otherwise an edge emitting the last address goes to END. Any other edge goes to RUN.

Top module: `serial_cfg_prom`

## Requirements
- R1: Parameter RST_HIGH selects the active level of `rst_oe`. With 1 (the default), a high level clears. With 0, a low level clears. No other behaviour depends on this setting.
- R2: After an edge sampling the clear level with `ce_n` low, the pointer is 0, `dout_en` is 0, and the next enabled edge emits address 0.
- R3: After an edge sampling `ce_n` low and `rst_oe` inactive, `dout_en` is 1 and `dout` carries the bit at the pointer's value before that edge. The pointer then steps by one.
- R4: An edge sampling `ce_n` high with `rst_oe` inactive leaves the pointer unchanged and drives `dout_en` low.
- R5: After each edge, `standby` equals the `ce_n` level that edge sampled.
- R6: The pointer saturates at DEPTH-1. Every further enabled edge presents the bit at DEPTH-1 again.
- R7: If `ce_n` goes high and returns low with `rst_oe` inactive throughout, streaming resumes at the next unread address.
- R8: A preload write (`pl_we` high on an edge) stores `pl_bit` at `pl_addr` and does not move the pointer.
- R9: `dout` is 0 whenever `dout_en` is 0.
- R10: An edge sampling the clear level with `ce_n` high clears the pointer to 0, raises `standby` and keeps `dout_en` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read clock from the loader |
| ce_n | input | 1 | Chip enable, active low; high means standby |
| rst_oe | input | 1 | Pointer clear / output disable, level set by RST_HIGH |
| pl_we | input | 1 | Preload write strobe |
| pl_addr | input | AW | Preload address |
| pl_bit | input | 1 | Preload data bit |
| dout | output | 1 | Serial data, 0 when not driven |
| dout_en | output | 1 | Output drive enable (models the tri-state condition) |
| standby | output | 1 | High while the last edge saw chip enable off |

## Verification
The bench preloads an irregular pattern and checks every streamed bit against its own image. A pointer that skipped or repeated an address would show up as a bit mismatch within a few edges. It pauses the stream with chip enable and rewrites a pending address during the pause. A design that lost its pointer, or that let preload writes disturb it, would resume at the wrong bit or show the stale value. It runs past the last address to catch a pointer that wraps to zero instead of holding. A second instance with the opposite clear polarity catches any inverted polarity decode. That fault would either block streaming or never clear the pointer.

// File: rtl/prom_pkg.sv
package prom_pkg;
    // Outcome of the most recent clock edge
    typedef enum logic [1:0] {
        ST_SLEEP = 2'd0,
        ST_CLEAR = 2'd1,
        ST_RUN   = 2'd2,
        ST_END   = 2'd3
    } prom_state_e;
endpackage

// File: rtl/prom_bit_array.sv
module prom_bit_array #(
    parameter int DEPTH = 2048,
    parameter int AW    = 11
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_bit,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_bit
);
    localparam logic [AW:0] DEPTH_W = AW'(DEPTH) == '0 ? {1'b1, {AW{1'b0}}} : {1'b0, AW'(DEPTH)};

    logic mem [DEPTH];
    logic rd_q;

    always_ff @(posedge clk) begin
        if (wr_en && ({1'b0, wr_addr} < DEPTH_W)) begin
            mem[wr_addr] <= wr_bit;
        end
        if (rd_en) begin
            rd_q <= mem[rd_addr];
        end
    end

    assign rd_bit = rd_q;
endmodule

// File: rtl/prom_seq_ctrl.sv
module prom_seq_ctrl
    import prom_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int AW    = 11
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          ce_act,
    output logic [AW-1:0] ptr,
    output logic          adv,
    output logic          drive_en,
    output logic          sleep
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    prom_state_e state, state_nxt;
    logic [AW-1:0] ptr_q;

    assign adv = ce_act & ~clr;

    // Next state: decided by the controls sampled at this edge
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_SLEEP, ST_CLEAR, ST_RUN, ST_END: begin
                if (!ce_act)             state_nxt = ST_SLEEP;
                else if (clr)            state_nxt = ST_CLEAR;
                else if (ptr_q == LAST)  state_nxt = ST_END;
                else                     state_nxt = ST_RUN;
            end
            default: state_nxt = ST_SLEEP;
        endcase
    end

    // State and pointer registers
    always_ff @(posedge clk) begin
        state <= state_nxt;
        if (clr) begin
            ptr_q <= '0;
        end else if (adv && (ptr_q != LAST)) begin
            ptr_q <= ptr_q + AW'(1);
        end
    end

    // Outputs decoded from state
    always_comb begin
        drive_en = 1'b0;
        sleep    = 1'b0;
        unique case (state)
            ST_SLEEP: sleep    = 1'b1;
            ST_CLEAR: drive_en = 1'b0;
            ST_RUN:   drive_en = 1'b1;
            ST_END:   drive_en = 1'b1;
            default:  sleep    = 1'b0;
        endcase
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/serial_cfg_prom.sv
module serial_cfg_prom #(
    parameter int DEPTH    = 2048,
    parameter bit RST_HIGH = 1'b1,
    parameter int AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          ce_n,
    input  logic          rst_oe,
    input  logic          pl_we,
    input  logic [AW-1:0] pl_addr,
    input  logic          pl_bit,
    output logic          dout,
    output logic          dout_en,
    output logic          standby
);
    logic          rst_act;
    logic          ce_act;
    logic [AW-1:0] rd_ptr;
    logic          adv;
    logic          drv;
    logic          slp;
    logic          rd_bit;

    // Polarity resolved once; the rest sees an active-high clear
    generate
        if (RST_HIGH) begin : g_clr_hi
            assign rst_act = rst_oe;
        end else begin : g_clr_lo
            assign rst_act = ~rst_oe;
        end
    endgenerate

    assign ce_act = ~ce_n;

    prom_seq_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
        .clk      (clk),
        .clr      (rst_act),
        .ce_act   (ce_act),
        .ptr      (rd_ptr),
        .adv      (adv),
        .drive_en (drv),
        .sleep    (slp)
    );

    prom_bit_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
        .clk     (clk),
        .wr_en   (pl_we),
        .wr_addr (pl_addr),
        .wr_bit  (pl_bit),
        .rd_en   (adv),
        .rd_addr (rd_ptr),
        .rd_bit  (rd_bit)
    );

    assign dout_en = drv;
    assign dout    = drv & rd_bit;
    assign standby = slp;
endmodule

// File: rtl/serial_cfg_prom_chk.sv
module serial_cfg_prom_chk #(
    parameter int DEPTH = 2048,
    parameter int AW    = 11
) (
    input logic          clk,
    input logic          ce_n,
    input logic          rst_act,
    input logic [AW-1:0] ptr,
    input logic          dout,
    input logic          dout_en,
    input logic          standby
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic was_clr = 1'b0;
    always_ff @(posedge clk) was_clr <= rst_act;

    // R2 R10
    always_ff @(posedge clk) begin
        if (was_clr) ptr_cleared_chk: assert (ptr == '0);
    end

    // R5
    standby_follow_chk: assert property (@(posedge clk) disable iff (rst_act)
        ce_n |=> standby);

    // R4
    frozen_ptr_chk: assert property (@(posedge clk) disable iff (rst_act)
        (ce_n && !rst_act) |=> ($stable(ptr) && !dout_en));

    // R3
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst_act)
        (!ce_n && !rst_act && ptr != LAST) |=> (ptr == $past(ptr) + AW'(1) && dout_en));

    // R6
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst_act)
        (!ce_n && !rst_act && ptr == LAST) |=> (ptr == LAST));

    // R9
    quiet_out_chk: assert property (@(posedge clk) disable iff (rst_act)
        !dout_en |-> !dout);
endmodule

bind serial_cfg_prom serial_cfg_prom_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
    .clk     (clk),
    .ce_n    (ce_n),
    .rst_act (rst_act),
    .ptr     (rd_ptr),
    .dout    (dout),
    .dout_en (dout_en),
    .standby (standby)
);

// File: tb/test_serial_cfg_prom.sv
`timescale 1ns/1ps
module test_serial_cfg_prom;
    localparam int DEPTH = 40;
    localparam int AW    = $clog2(DEPTH);

    logic clk = 1'b0;
    logic ce_n = 1'b0;
    logic rst_oe = 1'b1;
    logic rst_lo = 1'b0;
    logic pl_we = 1'b0;
    logic [AW-1:0] pl_addr = '0;
    logic pl_bit = 1'b0;
    logic dout, dout_en, standby;
    logic dout_l, dout_en_l, standby_l;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    int idx = 0;
    logic img [DEPTH];

    always #2.5 clk = ~clk;

    serial_cfg_prom #(.DEPTH(DEPTH), .RST_HIGH(1'b1)) i_serial_cfg_prom (
        .clk(clk), .ce_n(ce_n), .rst_oe(rst_oe), .pl_we(pl_we),
        .pl_addr(pl_addr), .pl_bit(pl_bit),
        .dout(dout), .dout_en(dout_en), .standby(standby));

    serial_cfg_prom #(.DEPTH(DEPTH), .RST_HIGH(1'b0)) i_serial_cfg_prom_lo (
        .clk(clk), .ce_n(ce_n), .rst_oe(rst_lo), .pl_we(pl_we),
        .pl_addr(pl_addr), .pl_bit(pl_bit),
        .dout(dout_l), .dout_en(dout_en_l), .standby(standby_l));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic pat(input int i);
        return logic'(((i * 7) ^ (i >> 2) ^ (i / 5)) & 1);
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // R2 R9: clear held with chip enabled
    task automatic t_reset();
        rst_oe = 1'b1; ce_n = 1'b0;
        tick(); tick();
        chk(dout_en == 1'b0, "R2 dout_en in clear", int'(dout_en), 0);
        chk(dout == 1'b0, "R9 dout while undriven", int'(dout), 0);
        chk(standby == 1'b0, "R5 standby low with ce active", int'(standby), 0);
    endtask

    // R8: fill the array
    task automatic t_preload();
        for (int i = 0; i < DEPTH; i++) begin
            pl_we = 1'b1; pl_addr = AW'(i); pl_bit = pat(i); img[i] = pat(i);
            tick();
        end
        pl_we = 1'b0;
    endtask

    // R3: stream n bits
    task automatic t_stream(input int n);
        rst_oe = 1'b0; ce_n = 1'b0;
        for (int k = 0; k < n; k++) begin
            tick();
            chk(dout_en == 1'b1, "R3 dout_en while streaming", int'(dout_en), 1);
            chk(dout == img[idx], "R3 streamed bit", int'(dout), int'(img[idx]));
            if (idx < DEPTH - 1) idx++;
        end
    endtask

    // R4 R5 R7 R8: pause, rewrite a pending bit, resume
    task automatic t_pause();
        ce_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk(standby == 1'b1, "R5 standby with ce off", int'(standby), 1);
            chk(dout_en == 1'b0, "R4 output off in standby", int'(dout_en), 0);
            chk(dout == 1'b0, "R9 dout in standby", int'(dout), 0);
        end
        pl_we = 1'b1; pl_addr = AW'(idx); pl_bit = ~img[idx]; img[idx] = ~img[idx];
        tick();
        pl_we = 1'b0;
        ce_n = 1'b0;
        tick();
        chk(standby == 1'b0, "R5 standby drops", int'(standby), 0);
        chk(dout == img[idx], "R7 R8 resume at next bit with new value", int'(dout), int'(img[idx]));
        idx++;
        t_stream(3);
    endtask

    // R6: run past the end
    task automatic t_saturate();
        t_stream(DEPTH - idx);
        for (int k = 0; k < 3; k++) begin
            tick();
            chk(dout == img[DEPTH-1] && dout_en, "R6 holds last bit", int'(dout), int'(img[DEPTH-1]));
        end
    endtask

    // R10: clear while in standby
    task automatic t_clear_standby();
        ce_n = 1'b1; rst_oe = 1'b1;
        tick();
        chk(standby == 1'b1, "R10 standby during clear", int'(standby), 1);
        chk(dout_en == 1'b0, "R10 output off", int'(dout_en), 0);
        rst_oe = 1'b0; ce_n = 1'b0;
        idx = 0;
        tick();
        chk(dout == img[0] && dout_en, "R10 R2 restart at address 0", int'(dout), int'(img[0]));
        idx = 1;
        t_stream(2);
    endtask

    // R1: inverted clear polarity
    task automatic t_polarity();
        ce_n = 1'b0; rst_lo = 1'b0;
        tick();
        chk(dout_en_l == 1'b0, "R1 low level clears", int'(dout_en_l), 0);
        rst_lo = 1'b1;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk(dout_l == img[k] && dout_en_l, "R1 stream with low-active clear", int'(dout_l), int'(img[k]));
        end
        rst_lo = 1'b0;
    endtask

    initial begin
        t_reset();
        t_preload();
        tick();
        chk(dout_en == 1'b0, "R8 preload leaves output idle", int'(dout_en), 0);
        t_stream(5);
        t_pause();
        t_saturate();
        t_clear_standby();
        t_polarity();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule